// File: doc/BRIEF.md
# Banked Interrupt Controller

This block gathers up to 81 interrupt sources into two processor request lines. Each source has three control bits of its own: an enable that lets it become pending, a mask that keeps it off the outputs, and a route bit that steers it to the normal request line or to the fast request line. The per-source bits are packed into 32-bit banks, so three banks cover the whole range. Bank `b` of any per-source register sits 4·b bytes above bank 0.

Source 0 is an external non-maskable input. It is edge-detected with a programmable polarity and latched. Software releases it by writing a one to bit 0 of the first normal-pending bank. Sources 1 to 80 are level inputs whose pending bits follow the pins. A vector word gives the handler address of the lowest-numbered active normal-line source, relative to a programmable base. A guard bit can restrict every register write to privileged accesses.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, all enable bits and route bits read 0, mask bits read 1 for sources 0..80, base/guard/edge-mode read 0, and both request outputs are low.
- R2: Word offsets are decoded from `bus_addr[7:2]`, and `bus_addr[1:0]` is ignored. Control words are at 0x00 (vector), 0x04 (base), 0x08 (guard, bit 0) and 0x0C (edge mode, bits 1:0). The per-source groups are normal-pending at 0x10, fast-pending at 0x20, route at 0x30, enable at 0x40 and mask at 0x50, with bank b at +4·b; bit i of bank b is source 32·b+i. Any other offset reads 0 and ignores writes.
- R3: A level source k (1..80, pin `periph_in[k-1]`) is pending exactly while its pin is high and its enable bit is 1. Pending reads reflect the pins with no added delay.
- R4: The normal-pending group reads pending sources whose route bit is 0. The fast-pending group reads those whose route bit is 1.
- R5: `irq_out` (`fiq_out`) is high one clock after any pending, unmasked source with route bit 0 (1) exists, and low one clock after none does.
- R6: A mask bit of 1 keeps its source off both outputs and out of the vector, while its pending bit stays visible.
- R7: Source 0 latches when its enable bit is 1 and an edge of the type set by the edge mode occurs on `nmi_in`: 0 falling, 1 rising, 2 or 3 either edge. Once latched it stays set.
- R8: A write to 0x10 with bit 0 set clears the latched source 0. All other bits written to the pending groups have no effect. An edge in the same cycle as the clear leaves it set.
- R9: The vector reads base + 4·n, where n is the lowest-numbered pending, unmasked source with route bit 0. It reads 0 when there is no such source. Base bits 1:0 always read 0.
- R10: While the guard bit is 1, writes with `bus_priv` low change nothing, including the guard bit and the source 0 clear. Writes with `bus_priv` high always take effect.
- R11: Bits for sources 81..95 read 0 in every group and ignore writes. Bank index 3 reads 0.
- R12: The edge-mode word keeps only bits 1:0, and its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periph_in | input | 80 | Level inputs for sources 1..80 |
| nmi_in | input | 1 | External input for source 0 |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Normal request line, registered |
| fiq_out | output | 1 | Fast request line, registered |

## Verification
The assertions assume that `nmi_in` and `periph_in` are synchronous to `clk`, because the block samples them without synchronizers. They also assume at most one write per cycle on a stable address. The stimulus changes every pin and bus signal only at falling edges. It holds each write for exactly one rising edge, and it waits two rising edges after a pin change before reading the registered outputs. Source 0 edges are produced by separate pin transitions spaced by at least two clocks, except where a clear and an edge are made to coincide on purpose.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int WORD_W   = 32;
    localparam int BANK_LSB = 2;
    localparam int GRP_LSB  = 4;

    // Register groups selected by address bits 7:4
    typedef enum logic [3:0] {
        GRP_CTRL   = 4'h0,
        GRP_IPEND  = 4'h1,
        GRP_FPEND  = 4'h2,
        GRP_ROUTE  = 4'h3,
        GRP_ENABLE = 4'h4,
        GRP_BLOCK  = 4'h5
    } grp_e;

    // Words inside the control group, address bits 3:2
    typedef enum logic [1:0] {
        CTL_VECTOR = 2'd0,
        CTL_BASE   = 2'd1,
        CTL_GUARD  = 2'd2,
        CTL_EDGE   = 2'd3
    } ctl_e;

    // Edge sensitivity of source 0
    typedef enum logic [1:0] {
        EDGE_FALL  = 2'd0,
        EDGE_RISE  = 2'd1,
        EDGE_ANY_A = 2'd2,
        EDGE_ANY_B = 2'd3
    } edge_e;

endpackage

// File: rtl/intc_lowest_pick.sv
module intc_lowest_pick #(
    parameter int W     = 96,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        // scan downward so the lowest set bit wins
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/intc_nmi_latch.sv
module intc_nmi_latch
    import intc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nmi_i,
    input  logic [1:0] mode_i,
    input  logic       enable_i,
    input  logic       clr_i,
    output logic       edge_o,
    output logic       pend_o
);

    typedef struct packed {
        logic prev;
        logic pend;
    } nmi_t;

    nmi_t s_d, s_q;
    logic rise, fall;

    always_comb begin
        rise = nmi_i & ~s_q.prev;
        fall = ~nmi_i & s_q.prev;
        case (edge_e'(mode_i))
            EDGE_FALL: edge_o = fall;
            EDGE_RISE: edge_o = rise;
            default:   edge_o = rise | fall;
        endcase
        s_d      = s_q;
        s_d.prev = nmi_i;
        // a fresh edge wins over a clear in the same cycle
        s_d.pend = (edge_o & enable_i) | (s_q.pend & ~clr_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_o = s_q.pend;

endmodule

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 81,
    parameter int NBANK   = (NUM_SRC + WORD_W - 1) / WORD_W,
    parameter int FLAT    = NBANK * WORD_W,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              priv_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [FLAT-1:0]   en_o,
    output logic [FLAT-1:0]   msk_o,
    output logic [FLAT-1:0]   sel_o,
    output logic [31:0]       base_o,
    output logic              guard_o,
    output logic [1:0]        mode_o,
    output logic              nmi_clr_o
);

    typedef struct packed {
        logic [FLAT-1:0] en;
        logic [FLAT-1:0] msk;
        logic [FLAT-1:0] sel;
        logic [31:0]     base;
        logic            guard;
        logic [1:0]      mode;
    } cfg_t;

    cfg_t            s_d, s_q, s_rst;
    logic [FLAT-1:0] exist;
    logic            wr_ok, hi_zero;
    logic [1:0]      bank;
    grp_e            grp;
    logic [1:0]      unused_lo;

    for (genvar i = 0; i < FLAT; i++) begin : g_exist
        assign exist[i] = 1'(i < NUM_SRC);
    end

    assign unused_lo = addr_i[1:0];
    assign hi_zero   = ((addr_i >> 8) == '0);
    assign bank      = addr_i[BANK_LSB +: 2];
    assign grp       = grp_e'(addr_i[GRP_LSB +: 4]);
    assign wr_ok     = wr_i & hi_zero & (~s_q.guard | priv_i);

    always_comb begin
        s_rst      = '0;
        s_rst.msk  = exist;
    end

    always_comb begin
        s_d       = s_q;
        nmi_clr_o = 1'b0;
        if (wr_ok) begin
            case (grp)
                GRP_CTRL: begin
                    case (ctl_e'(bank))
                        CTL_BASE:  s_d.base  = {wdata_i[31:2], 2'b00};
                        CTL_GUARD: s_d.guard = wdata_i[0];
                        CTL_EDGE:  s_d.mode  = wdata_i[1:0];
                        default:   ;
                    endcase
                end
                GRP_IPEND: begin
                    if (bank == 2'd0) nmi_clr_o = wdata_i[0];
                end
                GRP_ROUTE: begin
                    for (int b = 0; b < NBANK; b++)
                        if (int'(bank) == b)
                            s_d.sel[b*WORD_W +: WORD_W] = wdata_i & exist[b*WORD_W +: WORD_W];
                end
                GRP_ENABLE: begin
                    for (int b = 0; b < NBANK; b++)
                        if (int'(bank) == b)
                            s_d.en[b*WORD_W +: WORD_W] = wdata_i & exist[b*WORD_W +: WORD_W];
                end
                GRP_BLOCK: begin
                    for (int b = 0; b < NBANK; b++)
                        if (int'(bank) == b)
                            s_d.msk[b*WORD_W +: WORD_W] = wdata_i & exist[b*WORD_W +: WORD_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= s_rst;
        else        s_q <= s_d;
    end

    assign en_o    = s_q.en;
    assign msk_o   = s_q.msk;
    assign sel_o   = s_q.sel;
    assign base_o  = s_q.base;
    assign guard_o = s_q.guard;
    assign mode_o  = s_q.mode;

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 81,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-2:0] periph_in,
    input  logic               nmi_in,
    input  logic               bus_wr,
    input  logic               bus_priv,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_out,
    output logic               fiq_out
);

    localparam int NBANK = (NUM_SRC + WORD_W - 1) / WORD_W;
    localparam int FLAT  = NBANK * WORD_W;
    localparam int IDX_W = $clog2(FLAT);

    typedef struct packed {
        logic irq;
        logic fiq;
    } req_t;

    logic [FLAT-1:0]  en_f, msk_f, sel_f;
    logic [FLAT-1:0]  pend_all, irq_cand, fiq_cand;
    logic [31:0]      base_q, vector;
    logic             guard, nmi_clr, nmi_edge, nmi_pend;
    logic [1:0]       edge_mode;
    logic             vec_found;
    logic [IDX_W-1:0] vec_idx;
    logic [1:0]       bank;
    logic             bank_ok;
    logic [FLAT-1:0]  grp_sel;
    req_t             o_d, o_q;

    intc_cfg_regs #(
        .NUM_SRC (NUM_SRC),
        .NBANK   (NBANK),
        .FLAT    (FLAT),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (bus_wr),
        .priv_i    (bus_priv),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .en_o      (en_f),
        .msk_o     (msk_f),
        .sel_o     (sel_f),
        .base_o    (base_q),
        .guard_o   (guard),
        .mode_o    (edge_mode),
        .nmi_clr_o (nmi_clr)
    );

    intc_nmi_latch u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_i    (nmi_in),
        .mode_i   (edge_mode),
        .enable_i (en_f[0]),
        .clr_i    (nmi_clr),
        .edge_o   (nmi_edge),
        .pend_o   (nmi_pend)
    );

    always_comb begin
        pend_all               = '0;
        pend_all[0]            = nmi_pend;
        pend_all[NUM_SRC-1:1]  = periph_in & en_f[NUM_SRC-1:1];
        irq_cand               = pend_all & ~sel_f & ~msk_f;
        fiq_cand               = pend_all &  sel_f & ~msk_f;
    end

    intc_lowest_pick #(
        .W     (FLAT),
        .IDX_W (IDX_W)
    ) u_pick (
        .vec_i   (irq_cand),
        .found_o (vec_found),
        .idx_o   (vec_idx)
    );

    assign vector = vec_found ? (base_q + {{(30-IDX_W){1'b0}}, vec_idx, 2'b00}) : 32'd0;

    // read path
    assign bank    = bus_addr[BANK_LSB +: 2];
    assign bank_ok = (int'(bank) < NBANK) && ((bus_addr >> 8) == '0);

    always_comb begin
        case (grp_e'(bus_addr[GRP_LSB +: 4]))
            GRP_IPEND:  grp_sel = pend_all & ~sel_f;
            GRP_FPEND:  grp_sel = pend_all & sel_f;
            GRP_ROUTE:  grp_sel = sel_f;
            GRP_ENABLE: grp_sel = en_f;
            GRP_BLOCK:  grp_sel = msk_f;
            default:    grp_sel = '0;
        endcase
        bus_rdata = '0;
        if ((bus_addr >> 8) == '0 && grp_e'(bus_addr[GRP_LSB +: 4]) == GRP_CTRL) begin
            case (ctl_e'(bank))
                CTL_VECTOR: bus_rdata = vector;
                CTL_BASE:   bus_rdata = base_q;
                CTL_GUARD:  bus_rdata = {31'd0, guard};
                default:    bus_rdata = {30'd0, edge_mode};
            endcase
        end else if (bank_ok) begin
            bus_rdata = 32'(grp_sel >> (int'(bank) * WORD_W));
        end
    end

    // registered request lines
    always_comb begin
        o_d     = o_q;
        o_d.irq = |irq_cand;
        o_d.fiq = |fiq_cand;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign irq_out = o_q.irq;
    assign fiq_out = o_q.fiq;

endmodule

// File: rtl/banked_irq_ctrl_chk.sv
module banked_irq_ctrl_chk #(
    parameter int NUM_SRC = 81,
    parameter int FLAT    = 96
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic            bus_priv,
    input logic            guard,
    input logic [31:0]     base_q,
    input logic [FLAT-1:0] en_f,
    input logic [FLAT-1:0] msk_f,
    input logic [FLAT-1:0] sel_f,
    input logic            nmi_pend,
    input logic            nmi_clr,
    input logic            nmi_edge,
    input logic            irq_out,
    input logic            fiq_out
);

    logic all_blocked, none_fast;
    assign all_blocked = (msk_f[NUM_SRC-1:0] == '1);
    assign none_fast   = (sel_f == '0);

    // R6
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_blocked |=> (!irq_out && !fiq_out));

    // R4
    fast_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        none_fast |=> !fiq_out);

    // R10
    guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && guard && !bus_priv) |=>
            ($stable(base_q) && $stable(en_f) && $stable(msk_f) && $stable(sel_f) && $stable(guard)));

    // R7
    nmi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && !nmi_clr) |=> nmi_pend);

    // R8
    nmi_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_clr && !(nmi_edge && en_f[0])) |=> !nmi_pend);

endmodule

bind banked_irq_ctrl banked_irq_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .FLAT    (FLAT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_priv (bus_priv),
    .guard    (guard),
    .base_q   (base_q),
    .en_f     (en_f),
    .msk_f    (msk_f),
    .sel_f    (sel_f),
    .nmi_pend (nmi_pend),
    .nmi_clr  (nmi_clr),
    .nmi_edge (nmi_edge),
    .irq_out  (irq_out),
    .fiq_out  (fiq_out)
);

// File: tb/banked_irq_ctrl_test.sv
`timescale 1ns/1ps
module banked_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [79:0] periph_in = '0;
    logic        nmi_in = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_priv = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out, fiq_out;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    banked_irq_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .periph_in (periph_in),
        .nmi_in    (nmi_in),
        .bus_wr    (bus_wr),
        .bus_priv  (bus_priv),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out),
        .fiq_out   (fiq_out)
    );

    typedef struct packed {
        logic [7:0]  waddr;
        logic [31:0] wdata;
        logic [7:0]  raddr;
        logic [31:0] expv;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{8'h04, 32'h1000_0003, 8'h04, 32'h1000_0000, 4'd9},   // R9 base alignment
        '{8'h40, 32'hFFFF_FFFF, 8'h40, 32'hFFFF_FFFF, 4'd2},   // R2 enable bank 0
        '{8'h48, 32'hFFFF_FFFF, 8'h48, 32'h0001_FFFF, 4'd11},  // R11 enable bank 2 tail
        '{8'h58, 32'hFFFF_FFFF, 8'h58, 32'h0001_FFFF, 4'd11},  // R11 mask bank 2 tail
        '{8'h4C, 32'hFFFF_FFFF, 8'h4C, 32'h0000_0000, 4'd11},  // R11 bank index 3
        '{8'h0C, 32'hFFFF_FFFF, 8'h0C, 32'h0000_0003, 4'd12},  // R12 edge mode width
        '{8'h0C, 32'h0000_0000, 8'h0C, 32'h0000_0000, 4'd12},  // R12 back to falling
        '{8'h36, 32'h0000_00F0, 8'h34, 32'h0000_00F0, 4'd2},   // R2 low address bits ignored
        '{8'h34, 32'h0000_0000, 8'h34, 32'h0000_0000, 4'd2},   // R2 route bank 1
        '{8'h60, 32'h0000_1234, 8'h60, 32'h0000_0000, 4'd2},   // R2 unmapped offset
        '{8'h14, 32'hFFFF_FFFF, 8'h14, 32'h0000_0000, 4'd8},   // R8 pending not writable
        '{8'h44, 32'h0000_0000, 8'h44, 32'h0000_0000, 4'd2}    // R2 enable bank 1
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic p);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_priv = p; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_priv = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata, e, tag);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_nmi(input logic v);
        @(negedge clk);
        nmi_in = v;
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            wr(VECS[i].waddr, VECS[i].wdata, 1'b1);
            rd(VECS[i].raddr, VECS[i].expv, $sformatf("R%0d table %0d", VECS[i].req, i));
        end

        do_reset();
        // R1 reset state
        rd(8'h40, 32'h0, "R1 enable bank 0");
        rd(8'h48, 32'h0, "R1 enable bank 2");
        rd(8'h50, 32'hFFFF_FFFF, "R1 mask bank 0");
        rd(8'h58, 32'h0001_FFFF, "R1 mask bank 2");
        rd(8'h30, 32'h0, "R1 route bank 0");
        rd(8'h08, 32'h0, "R1 guard");
        rd(8'h00, 32'h0, "R1 vector");
        check({30'd0, irq_out, fiq_out}, 32'd0, "R1 outputs");

        // R3 level sources
        wr(8'h04, 32'h0000_0100, 1'b1);
        @(negedge clk); periph_in[4] = 1'b1;
        settle();
        rd(8'h10, 32'h0, "R3 disabled source not pending");
        wr(8'h40, 32'h0000_0020, 1'b1);
        rd(8'h10, 32'h0000_0020, "R3 enabled source pending");
        settle();
        check({31'd0, irq_out}, 32'd0, "R6 masked source off irq");
        rd(8'h00, 32'h0, "R6 masked source not in vector");
        wr(8'h50, 32'hFFFF_FFDF, 1'b1);
        settle();
        check({31'd0, irq_out}, 32'd1, "R5 irq raised");
        rd(8'h00, 32'h0000_0114, "R9 vector source 5");

        // R4 fast routing, source 40
        @(negedge clk); periph_in[39] = 1'b1;
        wr(8'h44, 32'h0000_0100, 1'b1);
        wr(8'h34, 32'h0000_0100, 1'b1);
        wr(8'h54, 32'hFFFF_FEFF, 1'b1);
        settle();
        rd(8'h24, 32'h0000_0100, "R4 fast pending bank 1");
        rd(8'h14, 32'h0, "R4 normal pending bank 1");
        check({31'd0, fiq_out}, 32'd1, "R5 fiq raised");
        rd(8'h00, 32'h0000_0114, "R9 fast source not in vector");

        @(negedge clk); periph_in[4] = 1'b0;
        settle();
        rd(8'h10, 32'h0, "R3 pending follows pin low");
        check({31'd0, irq_out}, 32'd0, "R5 irq dropped");
        rd(8'h00, 32'h0, "R9 empty vector");

        // bank 2, lowest wins
        @(negedge clk); periph_in[79] = 1'b1; periph_in[69] = 1'b1;
        wr(8'h48, 32'h0001_0040, 1'b1);
        wr(8'h58, 32'h0, 1'b1);
        settle();
        rd(8'h00, 32'h0000_0218, "R9 lowest of 70 and 80");
        rd(8'h18, 32'h0001_0040, "R3 bank 2 pending");
        check({31'd0, irq_out}, 32'd1, "R5 irq from bank 2");

        wr(8'h50, 32'hFFFF_FFFF, 1'b1);
        wr(8'h54, 32'hFFFF_FFFF, 1'b1);
        wr(8'h58, 32'hFFFF_FFFF, 1'b1);
        settle();
        check({30'd0, irq_out, fiq_out}, 32'd0, "R6 all masked");
        rd(8'h18, 32'h0001_0040, "R6 pending still visible");
        rd(8'h24, 32'h0000_0100, "R6 fast pending still visible");

        // source 0
        @(negedge clk); periph_in = '0;
        wr(8'h44, 32'h0, 1'b1);
        wr(8'h48, 32'h0, 1'b1);
        wr(8'h40, 32'h0000_0001, 1'b1);
        wr(8'h50, 32'hFFFF_FFFE, 1'b1);
        set_nmi(1'b1);
        rd(8'h10, 32'h0, "R7 rise ignored in falling mode");
        set_nmi(1'b0);
        rd(8'h10, 32'h1, "R7 falling edge latched");
        check({31'd0, irq_out}, 32'd1, "R5 irq from source 0");
        rd(8'h00, 32'h0000_0100, "R9 vector source 0");
        set_nmi(1'b1);
        rd(8'h10, 32'h1, "R7 latch sticky");
        wr(8'h10, 32'hFFFF_FFFE, 1'b1);
        rd(8'h10, 32'h1, "R8 clear needs bit 0");
        wr(8'h10, 32'h0000_0001, 1'b1);
        rd(8'h10, 32'h0, "R8 clear");
        settle();
        check({31'd0, irq_out}, 32'd0, "R5 irq after clear");

        wr(8'h0C, 32'h1, 1'b1);
        set_nmi(1'b0);
        rd(8'h10, 32'h0, "R7 fall ignored in rising mode");
        set_nmi(1'b1);
        rd(8'h10, 32'h1, "R7 rising edge latched");
        wr(8'h10, 32'h1, 1'b1);

        wr(8'h0C, 32'h2, 1'b1);
        set_nmi(1'b0);
        rd(8'h10, 32'h1, "R7 either mode falling");
        wr(8'h10, 32'h1, 1'b1);
        set_nmi(1'b1);
        rd(8'h10, 32'h1, "R7 either mode rising");
        wr(8'h10, 32'h1, 1'b1);

        // edge coincides with clear
        wr(8'h0C, 32'h1, 1'b1);
        set_nmi(1'b0);
        @(negedge clk);
        nmi_in = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h1; bus_priv = 1'b1; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_priv = 1'b0;
        rd(8'h10, 32'h1, "R8 edge wins over clear");
        wr(8'h10, 32'h1, 1'b1);

        wr(8'h40, 32'h0, 1'b1);
        set_nmi(1'b0);
        set_nmi(1'b1);
        rd(8'h10, 32'h0, "R7 disabled source 0 not latched");

        // R10 guard
        wr(8'h40, 32'h1, 1'b1);
        wr(8'h08, 32'h1, 1'b1);
        rd(8'h08, 32'h1, "R10 guard set");
        wr(8'h04, 32'h0000_2000, 1'b0);
        rd(8'h04, 32'h0000_0100, "R10 plain write dropped");
        wr(8'h08, 32'h0, 1'b0);
        rd(8'h08, 32'h1, "R10 guard not clearable plainly");
        set_nmi(1'b0);
        set_nmi(1'b1);
        rd(8'h10, 32'h1, "R10 source 0 pending");
        wr(8'h10, 32'h1, 1'b0);
        rd(8'h10, 32'h1, "R10 plain clear dropped");
        wr(8'h04, 32'h0000_2000, 1'b1);
        rd(8'h04, 32'h0000_2000, "R10 privileged write");

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule